// File: doc/BRIEF.md
# Configurable SPI Master/Slave Controller

This block is a single SPI port that a control bit sets to bus master or bus slave. All traffic passes through one shift register. A write buffer holds the byte that goes out. A read buffer receives each finished byte. Software reaches the block through a small byte-wide register port with a control register, a status register and a data register. Bits travel MSB first in SPI mode 0. The clock idles low, the sender changes data after a falling edge, and the receiver samples on the rising edge.

As master, the block starts a transfer when software writes the data register while no transfer is running. It then produces eight shift-clock pulses, paced either by a divider of the system clock or by an external timer-overflow pulse. As slave, it passes the incoming shift clock, select and data through two-flop synchronizers. It follows the select line: raising select abandons the partly received byte. Two slave options change this. One keeps the slave always selected, for 3-wire use. The other keeps the data output undriven while reception continues. After a full byte, a sticky done flag is set, and this flag is the interrupt output. For slave mode the system clock must run at least four times as fast as the shift clock.

Top module: `spi_core`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, `irq` is 0, `sck_o` is 0, and all three output enables are 0.
- R2: In master mode (control bit 0 = enable, bit 1 = master), a write to the data register (address 2) while idle sends that byte MSB first on `mosi_o` over exactly 8 `sck_o` pulses. It also captures 8 bits from `miso_i`, and a read of address 2 returns them.
- R3: Control bits [3:2] select the master shift-clock period: 4, 8, 32 or 64 system clocks for values 0, 1, 2 and 3.
- R4: With control bit 4 set, the master clock advances one half period per `tmr_tick` pulse, and does not move at all when no pulse arrives.
- R5: Status bit 0 (address 1) sets after the 8th bit of a byte and drives `irq`. Writing 1 to it clears it, and writing 0 leaves it set.
- R6: With the enable bit at 0, writing the data register starts no transfer, `sck_o` stays 0, and all output enables are 0.
- R7: A selected slave (`ss_n_i` low) receives the byte on `mosi_i` into the read buffer. During the same byte it returns the write-buffer byte MSB first on `miso_o`.
- R8: In slave mode, raising `ss_n_i` during a byte discards the partial bits without setting the done flag. The next byte after select is reasserted is received whole and correctly.
- R9: A slave with `ss_n_i` high (and control bit 5 clear) receives nothing, leaves the flag and read buffer unchanged, and keeps `miso_oe` at 0.
- R10: With control bit 5 set, the slave is selected regardless of `ss_n_i` and both receives and transmits.
- R11: With control bit 6 set, `miso_oe` stays 0 while the slave is selected, and the received byte still reaches the read buffer.
- R12: In master mode, `mosi_o` changes only while `sck_o` is low, and never between a rising and the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after address |
| irq | output | 1 | Done flag / interrupt request |
| tmr_tick | input | 1 | External timer-overflow pulse for master clocking |
| sck_o | output | 1 | Master shift clock |
| sck_oe | output | 1 | Shift clock output enable |
| sck_i | input | 1 | Slave shift clock input |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data in |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
A wrong bit counter shows up at the ports within one byte. The done flag rises early or late, and the read buffer holds a rotated byte. After a select abort, a counter that was not cleared shows up on the very next byte. A wrong clock divider shows up between the first two `sck_o` rising edges. A shift register that is loaded or shifted at the wrong edge shows up as wrong `mosi_o` or `miso_o` bits inside the same transfer, and the peer model's captured byte exposes it once that byte ends.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  typedef struct packed {
    logic       spare;
    logic       no_sout;
    logic       ign_sel;
    logic       tick_sel;
    logic [1:0] rate;
    logic       master;
    logic       en;
  } ctrl_t;

  // half of the shift-clock period, in system clocks
  function automatic int unsigned half_len(input logic [1:0] r);
    case (r)
      2'd0: half_len = 2;
      2'd1: half_len = 4;
      2'd2: half_len = 16;
      default: half_len = 32;
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= INIT;
      q  <= INIT;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/spi_rate.sv
module spi_rate #(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       tick_sel,
  input  logic       ext_tick,
  output logic       half_tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'(spi_pkg::half_len(rate) - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign half_tick = run && (tick_sel ? ext_tick : (cnt == lim));
endmodule

// File: rtl/spi_core.sv
module spi_core #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          tmr_tick,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  import spi_pkg::*;

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  ctrl_t          ctrl;
  logic [DW-1:0]  wbuf, rbuf, sh, sh_nx;
  logic [BW-1:0]  bit_cnt;
  logic           done_f, busy, sck_q, rx_bit, sck_d;
  logic           ss_s, sck_s, mosi_s;
  logic           s_rise, s_fall, slave_act, m_tick, wr_data;

  spi_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_n_i, sck_i, mosi_i}),
    .q({ss_s, sck_s, mosi_s})
  );

  spi_rate #(.CW(CW)) u_rate (
    .clk(clk), .rst(rst),
    .run(ctrl.en && ctrl.master && busy),
    .rate(ctrl.rate), .tick_sel(ctrl.tick_sel),
    .ext_tick(tmr_tick), .half_tick(m_tick)
  );

  assign s_rise    = sck_s & ~sck_d;
  assign s_fall    = ~sck_s & sck_d;
  assign slave_act = ctrl.en & ~ctrl.master & (ctrl.ign_sel | ~ss_s);
  assign wr_data   = reg_we && (reg_addr == ADR_DATA);
  assign sh_nx     = {sh[DW-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      wbuf    <= '0;
      rbuf    <= '0;
      sh      <= '0;
      bit_cnt <= '0;
      done_f  <= 1'b0;
      busy    <= 1'b0;
      sck_q   <= 1'b0;
      rx_bit  <= 1'b0;
      sck_d   <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (reg_we && reg_addr == ADR_CTRL) ctrl <= ctrl_t'(reg_wdata[7:0]);
      if (wr_data) wbuf <= reg_wdata;
      if (reg_we && reg_addr == ADR_STAT && reg_wdata[0]) done_f <= 1'b0;

      if (!ctrl.en) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
        sck_q   <= 1'b0;
      end else if (ctrl.master) begin
        if (!busy) begin
          sck_q <= 1'b0;
          if (wr_data) begin
            busy    <= 1'b1;
            sh      <= reg_wdata;
            bit_cnt <= '0;
          end
        end else if (m_tick) begin
          sck_q <= ~sck_q;
          if (!sck_q) rx_bit <= miso_i;
          else begin
            sh      <= sh_nx;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) begin
              busy   <= 1'b0;
              rbuf   <= sh_nx;
              done_f <= 1'b1;
            end
          end
        end
      end else begin
        sck_q <= 1'b0;
        if (!slave_act) begin
          busy    <= 1'b0;
          bit_cnt <= '0;
          sh      <= wbuf;
        end else begin
          if (!busy) sh <= wr_data ? reg_wdata : wbuf;
          if (s_rise) begin
            rx_bit <= mosi_s;
            busy   <= 1'b1;
          end else if (s_fall && busy) begin
            sh      <= sh_nx;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) begin
              busy   <= 1'b0;
              rbuf   <= sh_nx;
              done_f <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADR_CTRL: reg_rdata <= {{(DW-8){1'b0}}, ctrl};
        ADR_STAT: reg_rdata <= {{(DW-1){1'b0}}, done_f};
        ADR_DATA: reg_rdata <= rbuf;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign irq     = done_f;
  assign sck_o   = sck_q;
  assign sck_oe  = ctrl.en & ctrl.master;
  assign mosi_o  = sh[DW-1];
  assign mosi_oe = ctrl.en & ctrl.master;
  assign miso_o  = sh[DW-1];
  assign miso_oe = slave_act & ~ctrl.no_sout;
endmodule

// File: rtl/spi_core_chk.sv
module spi_core_chk #(
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst,
  input spi_pkg::ctrl_t        ctrl,
  input logic                  slave_act,
  input logic                  busy,
  input logic [$clog2(DW)-1:0] bit_cnt,
  input logic                  sck_o,
  input logic                  mosi_o,
  input logic                  irq,
  input logic                  reg_we,
  input logic [1:0]            reg_addr,
  input logic [DW-1:0]         reg_wdata
);
  a_r6_clock_parks: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> !sck_o);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_we && reg_addr == 2'd1 && reg_wdata[0])) |=> irq);

  a_r5_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(busy));

  a_r8_select_reset: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && !ctrl.master && !slave_act) |=> (!busy && bit_cnt == '0));

  a_r12_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && ctrl.master && sck_o && $past(sck_o)) |-> $stable(mosi_o));
endmodule

bind spi_core spi_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .slave_act(slave_act), .busy(busy),
  .bit_cnt(bit_cnt), .sck_o(sck_o), .mosi_o(mosi_o), .irq(irq),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_spi_core.sv
module sim_spi_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  // master under test (u0) with a behavioural peer slave
  logic       m_we = 1'b0, tick = 1'b0;
  logic [1:0] m_addr = 2'd0;
  logic [7:0] m_wd = 8'd0, m_rd;
  logic       u0_irq, u0_sck_o, u0_sck_oe, u0_mosi_o, u0_mosi_oe, u0_miso_o, u0_miso_oe;
  logic [7:0] bm_tx = 8'd0, bm_rx = 8'd0;
  logic [2:0] fcnt = 3'd0;
  always @(negedge u0_sck_o) fcnt <= fcnt + 3'd1;
  always @(posedge u0_sck_o) bm_rx <= {bm_rx[6:0], u0_mosi_o};

  spi_core u0 (
    .clk(clk), .rst(rst), .reg_we(m_we), .reg_addr(m_addr), .reg_wdata(m_wd),
    .reg_rdata(m_rd), .irq(u0_irq), .tmr_tick(tick),
    .sck_o(u0_sck_o), .sck_oe(u0_sck_oe), .sck_i(1'b0),
    .mosi_o(u0_mosi_o), .mosi_oe(u0_mosi_oe), .mosi_i(1'b0),
    .miso_o(u0_miso_o), .miso_oe(u0_miso_oe), .miso_i(bm_tx[~fcnt]),
    .ss_n_i(1'b1)
  );

  // slave under test (u1) driven by a behavioural master
  logic       s_we = 1'b0, s_sck = 1'b0, s_mosi = 1'b0, s_ss = 1'b1;
  logic [1:0] s_addr = 2'd0;
  logic [7:0] s_wd = 8'd0, s_rd;
  logic       u1_irq, u1_sck_o, u1_sck_oe, u1_mosi_o, u1_mosi_oe, u1_miso_o, u1_miso_oe;

  spi_core u1 (
    .clk(clk), .rst(rst), .reg_we(s_we), .reg_addr(s_addr), .reg_wdata(s_wd),
    .reg_rdata(s_rd), .irq(u1_irq), .tmr_tick(1'b0),
    .sck_o(u1_sck_o), .sck_oe(u1_sck_oe), .sck_i(s_sck),
    .mosi_o(u1_mosi_o), .mosi_oe(u1_mosi_oe), .mosi_i(s_mosi),
    .miso_o(u1_miso_o), .miso_oe(u1_miso_oe), .miso_i(1'b0),
    .ss_n_i(s_ss)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr0(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); m_we = 1'b1; m_addr = a; m_wd = d;
    @(negedge clk); m_we = 1'b0;
  endtask
  task automatic rd0(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); m_addr = a;
    @(negedge clk); d = m_rd;
  endtask
  task automatic wr1(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); s_we = 1'b1; s_addr = a; s_wd = d;
    @(negedge clk); s_we = 1'b0;
  endtask
  task automatic rd1(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); s_addr = a;
    @(negedge clk); d = s_rd;
  endtask

  // behavioural master for u1: half period 8 system clocks
  task automatic sxfer(input logic [7:0] tx, input int nbits, output logic [7:0] got,
                       output logic oe_seen);
    got = 8'd0; oe_seen = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      s_mosi = tx[7-i];
      repeat (8) @(negedge clk);
      oe_seen = oe_seen | u1_miso_oe;
      s_sck = 1'b1;
      got = {got[6:0], u1_miso_o};
      repeat (8) @(negedge clk);
      s_sck = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_irq0();
    for (int k = 0; k < 2000 && !u0_irq; k++) @(negedge clk);
  endtask

  // {rate, byte sent by master, byte returned by peer}
  localparam logic [17:0] VEC [4] = '{
    {2'd0, 8'hA5, 8'h3C},
    {2'd1, 8'h01, 8'h80},
    {2'd2, 8'hFF, 8'h00},
    {2'd3, 8'h6E, 8'hD9}
  };

  initial begin
    #(10 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, got;
    logic oe;
    int t1, t2;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd0(2'd0, d); chk("R1 ctrl", d, 0);
    rd0(2'd1, d); chk("R1 stat", d, 0);
    chk("R1 irq", u0_irq, 0);
    chk("R1 sck", u0_sck_o, 0);
    chk("R1 oe", {u0_sck_oe, u0_mosi_oe, u1_miso_oe}, 0);

    // R2 R3 master vectors over every rate
    for (int i = 0; i < 4; i++) begin
      wr0(2'd0, 8'h03 | (8'(VEC[i][17:16]) << 2));
      bm_tx = VEC[i][7:0];
      wr0(2'd2, VEC[i][15:8]);
      while (!u0_sck_o) @(negedge clk);
      t1 = cyc;
      while (u0_sck_o) @(negedge clk);
      while (!u0_sck_o) @(negedge clk);
      t2 = cyc;
      chk("R3 period", t2 - t1, 4 * (32'(spi_pkg::half_len(VEC[i][17:16]))) / 2);
      wait_irq0();
      chk("R5 flag set", u0_irq, 1);
      rd0(2'd2, d); chk("R2 rx byte", d, VEC[i][7:0]);
      chk("R2 tx byte", bm_rx, VEC[i][15:8]);
      chk("R2 clock idle", u0_sck_o, 0);
      wr0(2'd1, 8'h01);
    end

    // R5 write 0 leaves flag, write 1 clears
    wr0(2'd0, 8'h03);
    bm_tx = 8'h5A;
    wr0(2'd2, 8'h11);
    wait_irq0();
    wr0(2'd1, 8'h00);
    chk("R5 write0 keeps", u0_irq, 1);
    wr0(2'd1, 8'h01);
    chk("R5 write1 clears", u0_irq, 0);

    // R6 disabled: no transfer, outputs released
    wr0(2'd0, 8'h02);
    wr0(2'd2, 8'hC3);
    t1 = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (u0_sck_o) t1++;
    end
    chk("R6 no clock", t1, 0);
    chk("R6 no flag", u0_irq, 0);
    chk("R6 oe off", {u0_sck_oe, u0_mosi_oe}, 0);

    // R4 timer-tick clocking
    wr0(2'd0, 8'h13);
    bm_tx = 8'h0F;
    wr0(2'd2, 8'h81);
    repeat (50) @(negedge clk);
    chk("R4 no tick no clock", u0_sck_o, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R4 tick raises sck", u0_sck_o, 1);
    for (int k = 0; k < 15; k++) begin
      repeat (2) @(negedge clk);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk("R4 done after 16 ticks", u0_irq, 1);
    rd0(2'd2, d); chk("R4 rx byte", d, 8'h0F);
    chk("R4 tx byte", bm_rx, 8'h81);
    wr0(2'd1, 8'h01);

    // R7 selected slave
    wr1(2'd0, 8'h01);
    wr1(2'd2, 8'hA5);
    s_ss = 1'b0; repeat (8) @(negedge clk);
    sxfer(8'h3C, 8, got, oe);
    chk("R7 rx byte", u1_irq, 1);
    rd1(2'd2, d); chk("R7 rx data", d, 8'h3C);
    chk("R7 miso byte", got, 8'hA5);
    chk("R7 miso oe", oe, 1);
    wr1(2'd1, 8'h01);

    // R8 abort then aligned byte
    sxfer(8'hFF, 3, got, oe);
    s_ss = 1'b1; repeat (8) @(negedge clk);
    chk("R8 no flag after abort", u1_irq, 0);
    s_ss = 1'b0; repeat (8) @(negedge clk);
    sxfer(8'h96, 8, got, oe);
    rd1(2'd2, d); chk("R8 next byte aligned", d, 8'h96);
    chk("R8 flag", u1_irq, 1);
    wr1(2'd1, 8'h01);

    // R9 deselected slave is passive
    s_ss = 1'b1; repeat (8) @(negedge clk);
    sxfer(8'h11, 8, got, oe);
    chk("R9 no flag", u1_irq, 0);
    rd1(2'd2, d); chk("R9 rbuf kept", d, 8'h96);
    chk("R9 miso oe", oe, 0);

    // R10 ignore select
    wr1(2'd0, 8'h21);
    wr1(2'd2, 8'h7E);
    sxfer(8'h5A, 8, got, oe);
    rd1(2'd2, d); chk("R10 rx data", d, 8'h5A);
    chk("R10 miso byte", got, 8'h7E);
    chk("R10 miso oe", oe, 1);
    wr1(2'd1, 8'h01);

    // R11 output disabled while receiving
    wr1(2'd0, 8'h41);
    s_ss = 1'b0; repeat (8) @(negedge clk);
    sxfer(8'hC3, 8, got, oe);
    chk("R11 miso oe off", oe, 0);
    rd1(2'd2, d); chk("R11 rx data", d, 8'hC3);
    s_ss = 1'b1;

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule